// File: doc/BRIEF.md
# Four-Tap Polyphase Interpolation Filter

This block filters one colour component during image resampling. Each valid cycle it receives four neighbouring unsigned samples, a direction select (horizontal or vertical) and a fractional position. It returns one interpolated sample two cycles later. The position is a 6-bit phase that splits the distance between the two centre samples into 64 steps.

Coefficients sit in two register banks, one for each direction. Each bank holds only the lower half-interval of the phase range: 33 entries, each a 32-bit word that packs four 8-bit taps. Phases in the upper half reuse a mirrored entry with the tap order reversed. Software fills a bank by writing the index port once and then streaming 33 words into the data port. The block applies the taps, rounds, scales by 1/128 and clamps the result to the 10-bit sample range. `rst_n` is expected to arrive already synchronised to `clk`.

Top module: `poly4_scaler`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sample` is 0. Every coefficient word is 0, so any filtered sample is 0 until a bank is loaded. Data-port writes made before the first index write are ignored.
- R2: An index write (`cfg_idx_we`) selects the horizontal bank when `cfg_idx_horiz` is 1 and the vertical bank when it is 0. It rewinds the load position to entry 0. If a data write arrives in the same cycle as an index write, the index write wins and the data write is dropped.
- R3: After an index write, each data write (`cfg_data_we`) stores `cfg_data` into the next entry of the selected bank, from entry 0 up to entry 32 in order.
- R4: Once 33 entries have been written, further data writes have no effect until the next index write.
- R5: Within an entry, bits [31:24] weight sample 0, bits [23:16] weight sample 1, bits [15:8] weight sample 2 and bits [7:0] weight sample 3. Sample k occupies bits [10k+9:10k] of `in_samples`.
- R6: A tap byte is a signed two's-complement value, except the code 0x80, which means +128 (unity gain). A tap of −128 cannot be expressed.
- R7: `in_horiz`=1 filters with the horizontal bank and `in_horiz`=0 with the vertical bank.
- R8: A phase p from 0 to 32 uses entry p as stored. A phase p from 33 to 63 uses entry 64−p with the taps reversed: byte [7:0] weights sample 0 and byte [31:24] weights sample 3.
- R9: The sum of tap×sample over the four taps has 64 added and is then shifted right arithmetically by 7. This gives round-half-up division by 128.
- R10: The result is clamped to 0 when negative and to 1023 when above 1023.
- R11: `out_valid` equals `in_valid` from two cycles earlier. The output sample belongs to the inputs presented in that cycle.
- R12: In a cycle where `out_valid` is 0, `out_sample` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx_we | input | 1 | Index write strobe: selects a bank and rewinds the load position |
| cfg_idx_horiz | input | 1 | Bank chosen by an index write: 1 horizontal, 0 vertical |
| cfg_data_we | input | 1 | Coefficient data write strobe |
| cfg_data | input | 32 | Packed coefficient word (four tap bytes) |
| in_valid | input | 1 | Input sample set is valid |
| in_horiz | input | 1 | Bank used for this sample: 1 horizontal, 0 vertical |
| in_phase | input | 6 | Fractional position, 0 to 63 |
| in_samples | input | 40 | Four unsigned 10-bit samples, sample 0 in the low bits |
| out_valid | output | 1 | Filtered sample is valid |
| out_sample | output | 10 | Filtered, rounded and clamped sample |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 8-bit taps, a 6-bit phase, and therefore 33 entries in each bank. Under these values every phase from 0 to 63 can be swept in both directions with a few hundred inputs, and that sweep covers the mirrored half and the shared entry 32. Full-scale 10-bit samples combined with ±127 and +128 taps drive the accumulator past both clamp limits. Loads that overrun 33 words or coincide with an index write show whether the load position behaves at its ends.

// File: rtl/poly4_pkg.sv
package poly4_pkg;
  localparam int NTAPS = 4;

  typedef enum logic {
    BANK_VERT  = 1'b0,
    BANK_HORIZ = 1'b1
  } bank_e;
endpackage

// File: rtl/poly4_coef_store.sv
module poly4_coef_store #(
  parameter int WORD_W = 32,
  parameter int NPH    = 33,
  parameter int ENT_W  = 6,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              idx_horiz,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data,
  input  logic              rd_bank,
  input  logic [ENT_W-1:0]  rd_entry,
  output logic [WORD_W-1:0] rd_word,
  output logic [PTR_W-1:0]  load_ptr
);
  import poly4_pkg::*;

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NPH);

  logic [WORD_W-1:0] bank_q [2][NPH];
  bank_e             sel_q, sel_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              wr_en;

  always_comb begin
    sel_d = sel_q;
    ptr_d = ptr_q;
    wr_en = 1'b0;
    if (idx_we) begin
      sel_d = idx_horiz ? BANK_HORIZ : BANK_VERT;
      ptr_d = '0;
    end else if (data_we && (ptr_q < PTR_END)) begin
      wr_en = 1'b1;
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= BANK_VERT;
      ptr_q <= PTR_END;
    end else begin
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < NPH; e++)
          bank_q[b][e] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < NPH; e++)
          if ((sel_q == bank_e'(b)) && (ptr_q == PTR_W'(e)))
            bank_q[b][e] <= data;
    end
  end

  assign rd_word  = bank_q[rd_bank][rd_entry];
  assign load_ptr = ptr_q;
endmodule

// File: rtl/poly4_tap_select.sv
module poly4_tap_select #(
  parameter int TAP_W = 8,
  parameter int NTAPS = 4,
  parameter int PH_W  = 6,
  parameter int ENT_W = 6
) (
  input  logic [PH_W-1:0]              phase,
  input  logic [NTAPS*TAP_W-1:0]       word,
  output logic [ENT_W-1:0]             entry,
  output logic [NTAPS*(TAP_W+1)-1:0]   taps
);
  localparam int              HALF   = 2 ** (PH_W - 1);
  localparam logic [PH_W:0]   FULL   = {1'b1, {PH_W{1'b0}}};
  localparam logic [TAP_W-1:0] UNITY = {1'b1, {(TAP_W-1){1'b0}}};

  logic            mirror;
  logic [PH_W:0]   mirrored;

  assign mirror   = ({1'b0, phase} > (PH_W+1)'(HALF));
  assign mirrored = FULL - {1'b0, phase};
  assign entry    = mirror ? ENT_W'(mirrored) : ENT_W'(phase);

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic [TAP_W-1:0]        fwd_b, rev_b, raw;
    logic signed [TAP_W:0]   dec;
    assign fwd_b = word[(NTAPS-1-k)*TAP_W +: TAP_W];
    assign rev_b = word[k*TAP_W +: TAP_W];
    assign raw   = mirror ? rev_b : fwd_b;
    assign dec   = (raw == UNITY) ? $signed({1'b0, raw}) : $signed({raw[TAP_W-1], raw});
    assign taps[k*(TAP_W+1) +: (TAP_W+1)] = dec;
  end
endmodule

// File: rtl/poly4_mac.sv
module poly4_mac #(
  parameter int SAMP_W = 10,
  parameter int TAP_W  = 8,
  parameter int NTAPS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [NTAPS*SAMP_W-1:0]     samples,
  input  logic [NTAPS*(TAP_W+1)-1:0]  taps,
  output logic                        out_valid,
  output logic [SAMP_W-1:0]           out_sample
);
  localparam int PROD_W = SAMP_W + TAP_W + 2;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS);
  localparam int SHIFT  = TAP_W - 1;
  localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'((2 ** SAMP_W) - 1);

  logic signed [PROD_W-1:0] prod_d [NTAPS];
  logic signed [PROD_W-1:0] prod_q [NTAPS];
  logic                     v1_q;
  logic signed [ACC_W-1:0]  acc, scaled;
  logic [SAMP_W-1:0]        res_d;

  always_comb begin
    for (int k = 0; k < NTAPS; k++)
      prod_d[k] = PROD_W'($signed({1'b0, samples[k*SAMP_W +: SAMP_W]}) *
                          $signed(taps[k*(TAP_W+1) +: (TAP_W+1)]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      for (int k = 0; k < NTAPS; k++) prod_q[k] <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid)
        for (int k = 0; k < NTAPS; k++) prod_q[k] <= prod_d[k];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) acc = acc + ACC_W'(prod_q[k]);
    scaled = (acc + ROUND) >>> SHIFT;
    if (scaled < 0)         res_d = '0;
    else if (scaled > MAXV) res_d = {SAMP_W{1'b1}};
    else                    res_d = scaled[SAMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) out_sample <= res_d;
    end
  end
endmodule

// File: rtl/poly4_scaler.sv
module poly4_scaler #(
  parameter int SAMP_W = 10,
  parameter int TAP_W  = 8,
  parameter int PH_W   = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_idx_we,
  input  logic                                 cfg_idx_horiz,
  input  logic                                 cfg_data_we,
  input  logic [poly4_pkg::NTAPS*TAP_W-1:0]    cfg_data,
  input  logic                                 in_valid,
  input  logic                                 in_horiz,
  input  logic [PH_W-1:0]                      in_phase,
  input  logic [poly4_pkg::NTAPS*SAMP_W-1:0]   in_samples,
  output logic                                 out_valid,
  output logic [SAMP_W-1:0]                    out_sample
);
  import poly4_pkg::*;

  localparam int NPH    = 2 ** (PH_W - 1) + 1;
  localparam int ENT_W  = $clog2(NPH);
  localparam int PTR_W  = $clog2(NPH + 1);
  localparam int WORD_W = NTAPS * TAP_W;

  logic [ENT_W-1:0]              entry;
  logic [WORD_W-1:0]             word;
  logic [NTAPS*(TAP_W+1)-1:0]    taps;
  logic [PTR_W-1:0]              load_ptr;

  poly4_coef_store #(.WORD_W(WORD_W), .NPH(NPH), .ENT_W(ENT_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .idx_we(cfg_idx_we), .idx_horiz(cfg_idx_horiz),
    .data_we(cfg_data_we), .data(cfg_data),
    .rd_bank(in_horiz), .rd_entry(entry), .rd_word(word),
    .load_ptr(load_ptr)
  );

  poly4_tap_select #(.TAP_W(TAP_W), .NTAPS(NTAPS), .PH_W(PH_W), .ENT_W(ENT_W)) u_sel (
    .phase(in_phase), .word(word), .entry(entry), .taps(taps)
  );

  poly4_mac #(.SAMP_W(SAMP_W), .TAP_W(TAP_W), .NTAPS(NTAPS)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .samples(in_samples), .taps(taps),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/poly4_scaler_chk.sv
module poly4_scaler_chk #(
  parameter int SAMP_W = 10,
  parameter int NPH    = 33,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_idx_we,
  input logic              cfg_data_we,
  input logic              in_valid,
  input logic              out_valid,
  input logic [SAMP_W-1:0] out_sample,
  input logic [PTR_W-1:0]  load_ptr
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NPH);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R11
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd1) && !out_valid) |-> $stable(out_sample));

  // R2
  index_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idx_we |=> (load_ptr == '0));

  // R3
  load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_idx_we && (load_ptr < PTR_END)) |=> (load_ptr == $past(load_ptr) + 1'b1));

  // R4
  load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_idx_we && (load_ptr == PTR_END)) |=> $stable(load_ptr));

  // R4
  load_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ptr <= PTR_END);
endmodule

bind poly4_scaler poly4_scaler_chk #(.SAMP_W(SAMP_W), .NPH(NPH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_idx_we(cfg_idx_we), .cfg_data_we(cfg_data_we),
  .in_valid(in_valid), .out_valid(out_valid), .out_sample(out_sample),
  .load_ptr(load_ptr)
);

// File: tb/sim_poly4_scaler.sv
module sim_poly4_scaler;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 33;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_idx_we, cfg_idx_horiz, cfg_data_we;
  logic [31:0] cfg_data;
  logic        in_valid, in_horiz;
  logic [5:0]  in_phase;
  logic [39:0] in_samples;
  logic        out_valid;
  logic [9:0]  out_sample;

  int checks = 0;
  int failures = 0;

  logic [31:0] mbank [2][NPH];
  int          mptr;
  int          msel;
  bit          pv [3];
  int          pval [3];
  string       ptag [3];
  int          held;
  string       cur_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  poly4_scaler u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_idx_we(cfg_idx_we), .cfg_idx_horiz(cfg_idx_horiz),
    .cfg_data_we(cfg_data_we), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_horiz(in_horiz), .in_phase(in_phase),
    .in_samples(in_samples),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int model_out(int h, int ph, logic [39:0] s);
    int ent, acc, src, b, t, r;
    bit mir;
    mir = ph > 32;
    ent = mir ? 64 - ph : ph;
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      src = mir ? 3 - k : k;
      b = int'((mbank[h][ent] >> ((3 - src) * 8)) & 32'hff);
      t = (b == 128) ? 128 : ((b > 127) ? b - 256 : b);
      acc += t * int'(s[k*10 +: 10]);
    end
    r = (acc + 64) >>> 7;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  function automatic logic [31:0] gen_word(int kind, int p);
    int t0, t1, t2, t3;
    case (kind)
      0: begin t0 = -(p % 5); t1 = 128 - 2*p; t2 = 2*p; t3 = -(p % 3); end
      1: begin t0 = 3 + (p % 4); t1 = 61; t2 = 61 - (p % 7); t3 = 3; end
      default: case (p % 4)
        0: begin t0 = 127;  t1 = 127;  t2 = 127;  t3 = 127;  end
        1: begin t0 = 128;  t1 = 128;  t2 = 128;  t3 = 128;  end
        2: begin t0 = -127; t1 = -127; t2 = -127; t3 = -127; end
        default: begin t0 = -1; t1 = 64; t2 = 64; t3 = -1; end
      endcase
    endcase
    return {t0[7:0], t1[7:0], t2[7:0], t3[7:0]};
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    pv[2] = pv[1]; pval[2] = pval[1]; ptag[2] = ptag[1];
    pv[1] = in_valid;
    pval[1] = in_valid ? model_out(int'(in_horiz), int'(in_phase), in_samples) : 0;
    ptag[1] = cur_req;
    if (cfg_idx_we) begin
      msel = int'(cfg_idx_horiz);
      mptr = 0;
    end else if (cfg_data_we && mptr < NPH) begin
      mbank[msel][mptr] = cfg_data;
      mptr++;
    end
    @(negedge clk);
    check("R11", int'(out_valid), int'(pv[2]), "out_valid");
    if (pv[2]) begin
      check(ptag[2], int'(out_sample), pval[2], "out_sample");
      held = pval[2];
    end else begin
      check("R12", int'(out_sample), held, "held out_sample");
    end
    cfg_idx_we = 1'b0; cfg_data_we = 1'b0; in_valid = 1'b0;
  endtask

  task automatic drive(bit h, int ph, int s0, int s1, int s2, int s3);
    in_valid = 1'b1; in_horiz = h; in_phase = 6'(ph);
    in_samples = {10'(s3), 10'(s2), 10'(s1), 10'(s0)};
    tick();
  endtask

  task automatic load_bank(bit h, int kind, int extra);
    cfg_idx_we = 1'b1; cfg_idx_horiz = h;
    cfg_data_we = 1'b1; cfg_data = 32'h5a5a5a5a;   // R2: dropped, index wins
    tick();
    for (int p = 0; p < NPH; p++) begin
      cfg_data_we = 1'b1; cfg_data = gen_word(kind, p);
      tick();
    end
    for (int x = 0; x < extra; x++) begin           // R4: overrun writes
      cfg_data_we = 1'b1; cfg_data = 32'h3c3c3c3c;
      tick();
    end
  endtask

  task automatic sweep(bit h, int seed);
    for (int ph = 0; ph < 64; ph++) begin
      drive(h, ph, (ph*37 + seed) % 1024, (ph*91 + 3*seed) % 1024,
            (ph*53 + 7) % 1024, (ph*17 + seed*5) % 1024);
      if (ph % 9 == 4) tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < NPH; e++) mbank[b][e] = '0;
    mptr = NPH; msel = 0; held = 0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pval[i] = 0; ptag[i] = "R1"; end
    cur_req = "R1";
    rst_n = 1'b0;
    cfg_idx_we = 0; cfg_idx_horiz = 0; cfg_data_we = 0; cfg_data = '0;
    in_valid = 0; in_horiz = 0; in_phase = '0; in_samples = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(out_sample), 0, "out_sample after reset");
    // R1: data write before any index write is ignored
    cfg_data_we = 1'b1; cfg_data = 32'h00800000;
    tick();
    drive(1'b0, 0, 500, 600, 700, 800);
    drive(1'b1, 0, 500, 600, 700, 800);
    drive(1'b1, 40, 1023, 1023, 1023, 1023);
    tick(); tick();

    // R3 R5 R6 R8 R7: sharp kernel in horizontal bank, full phase sweep
    cur_req = "R3";
    load_bank(1'b1, 0, 0);
    cur_req = "R8";
    sweep(1'b1, 11);
    // R5: unity tap on sample 1 at phase 0
    cur_req = "R5";
    drive(1'b1, 0, 9, 321, 77, 5);
    cur_req = "R6";
    drive(1'b1, 0, 0, 1000, 0, 0);

    // R7: smooth kernel in vertical bank with overrun writes (R4)
    cur_req = "R4";
    load_bank(1'b0, 1, 3);
    cur_req = "R7";
    sweep(1'b0, 29);
    sweep(1'b1, 5);
    cur_req = "R8";
    drive(1'b0, 32, 100, 200, 300, 400);
    drive(1'b0, 33, 100, 200, 300, 400);
    drive(1'b0, 31, 100, 200, 300, 400);

    // R10 R9: extreme taps into vertical bank
    cur_req = "R6";
    load_bank(1'b0, 2, 1);
    cur_req = "R10";
    drive(1'b0, 0, 1023, 1023, 1023, 1023);
    drive(1'b0, 1, 1023, 1023, 1023, 1023);
    drive(1'b0, 2, 1023, 1023, 1023, 1023);
    drive(1'b0, 2, 0, 0, 0, 0);
    drive(1'b0, 6, 1023, 1023, 1023, 1023);
    drive(1'b0, 62, 5, 5, 5, 5);
    cur_req = "R9";
    drive(1'b0, 3, 0, 1, 0, 0);
    drive(1'b0, 3, 0, 1, 1, 0);
    drive(1'b0, 3, 65, 0, 0, 0);
    drive(1'b0, 3, 64, 1, 0, 0);
    drive(1'b0, 61, 0, 0, 0, 1);
    tick(); tick(); tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule